// File: doc/BRIEF.md
# Dual-Port Interprocessor Mailbox

This block gives two processors a small shared set of registers for passing work between them. One processor, the requester, places the address of a command structure in a request pointer. It then rings a doorbell bit. The other processor, the responder, takes the interrupt that the doorbell raises. When the job is done, the responder places the original pointer in a reply pointer and sets reply flags, which interrupt the requester. Each side clears the doorbells the other side rang, and that drops the matching interrupt.

Each side has its own simple register port: a write strobe, a read strobe, a byte address and 32-bit data. Read data is registered. The three registers sit at word offsets 0x0, 0x4 and 0x8 of a 0x400-byte window. That window repeats across a 0x6000-byte region. The two sides can write the flag register in the same cycle, and both updates take effect.

Top module: `mbox_regs`

## Requirements
- R1: Word 0x0 is the request pointer. A requester write stores the full 32 bits, both sides can read it, and responder writes to it are ignored.
- R2: Word 0x8 is the reply pointer. A responder write stores the full 32 bits, both sides can read it, and requester writes to it are ignored.
- R3: Word 0x4 is the flag register. The requester owns bits 0 and 1, and the responder owns bits 2, 3 and 4. Writing 1 to a bit the writer owns sets that bit. Writing 1 to a bit the other side owns clears it. Writing 0 leaves the bit unchanged. Bits 5 to 31 always read 0.
- R4: `rsp_irq` is high exactly while flag bit 0 is set. It follows the flag write on the same clock edge.
- R5: `req_irq` is high exactly while flag bit 2 or flag bit 4 is set. A responder write of 0x14 sets both bits and raises `req_irq`.
- R6: When both sides write the flag register in the same cycle, the set masks and clear masks of both writes are merged. If one side sets a bit and the other side clears the same bit, the bit ends up set.
- R7: Only the low 10 address bits select a register, so the window repeats every 0x400 bytes from 0x0000 to 0x5FFF. At 0x6000 and above, reads return 0 and writes are ignored.
- R8: Any offset within a window other than 0x0, 0x4 or 0x8 reads as 0 and ignores writes. Misaligned addresses are included.
- R9: Read data appears in the cycle after the read strobe. It shows the register value from before any write in that same cycle, and it is 0 in any cycle that follows no read.
- R10: A synchronous active-high reset clears all three registers, both interrupts and both read-data outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_wr | input | 1 | Requester write strobe |
| req_rd | input | 1 | Requester read strobe |
| req_addr | input | 16 | Requester byte address |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data, registered |
| rsp_wr | input | 1 | Responder write strobe |
| rsp_rd | input | 1 | Responder read strobe |
| rsp_addr | input | 16 | Responder byte address |
| rsp_wdata | input | 32 | Responder write data |
| rsp_rdata | output | 32 | Responder read data, registered |
| req_irq | output | 1 | Reply-ready interrupt to the requester |
| rsp_irq | output | 1 | Request-ready interrupt to the responder |

## Verification
A flag register in the wrong state shows up on the interrupt pins on the clock edge right after the write that caused it. A read of word 0x4 shows it one cycle later. A decode fault, such as a lost alias, a region bound at the wrong place or a stray offset, shows up as nonzero read data or as a changed register in the first read-back after the bad access. Merge faults in a same-cycle flag write are visible as soon as the next read of word 0x4. The bench places such reads and interrupt samples directly after each stimulus.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    SEL_REQ_PTR  = 2'd0,
    SEL_FLAGS    = 2'd1,
    SEL_RPLY_PTR = 2'd2,
    SEL_NONE     = 2'd3
  } mbox_sel_e;

  typedef struct packed {
    logic      wr;
    logic      rd;
    mbox_sel_e sel;
  } mbox_acc_t;

  localparam int unsigned SIDE_REQ = 0;
  localparam int unsigned SIDE_RSP = 1;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 1024,
  parameter int unsigned NUM_ALIAS = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output mbox_acc_t         acc
);
  localparam int unsigned OFF_W  = $clog2(WIN_BYTES);
  localparam int unsigned REGION = WIN_BYTES * NUM_ALIAS;

  logic             in_region;
  logic [OFF_W-1:0] off;
  mbox_sel_e        hit;

  assign in_region = ({1'b0, addr} < (ADDR_W+1)'(REGION));
  assign off       = addr[OFF_W-1:0];

  always_comb begin
    case (off)
      OFF_W'(0): hit = SEL_REQ_PTR;
      OFF_W'(4): hit = SEL_FLAGS;
      OFF_W'(8): hit = SEL_RPLY_PTR;
      default:   hit = SEL_NONE;
    endcase
  end

  always_comb begin
    acc.sel = in_region ? hit : SEL_NONE;
    acc.wr  = wr && (acc.sel != SEL_NONE);
    acc.rd  = rd;
  end

endmodule

// File: rtl/mbox_ptr.sv
module mbox_ptr #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] REQ_OWN  = 32'h0000_0003,
  parameter logic [DATA_W-1:0] RSP_OWN  = 32'h0000_001C,
  parameter logic [DATA_W-1:0] RSP_IRQM = 32'h0000_0001,
  parameter logic [DATA_W-1:0] REQ_IRQM = 32'h0000_0014
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_we,
  input  logic [DATA_W-1:0] rsp_wdata,
  output logic [DATA_W-1:0] flags_q,
  output logic              req_irq,
  output logic              rsp_irq
);
  logic [DATA_W-1:0] set_m, clr_m, flags_d;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (req_we) begin
      set_m = set_m | (req_wdata & REQ_OWN);
      clr_m = clr_m | (req_wdata & RSP_OWN);
    end
    if (rsp_we) begin
      set_m = set_m | (rsp_wdata & RSP_OWN);
      clr_m = clr_m | (rsp_wdata & REQ_OWN);
    end
    flags_d = (flags_q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      req_irq <= 1'b0;
      rsp_irq <= 1'b0;
    end else begin
      flags_q <= flags_d;
      req_irq <= |(flags_d & REQ_IRQM);
      rsp_irq <= |(flags_d & RSP_IRQM);
    end
  end
endmodule

// File: rtl/mbox_rdport.sv
module mbox_rdport
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  mbox_acc_t         acc,
  input  logic [DATA_W-1:0] req_ptr,
  input  logic [DATA_W-1:0] flags,
  input  logic [DATA_W-1:0] rply_ptr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mux;

  always_comb begin
    case (acc.sel)
      SEL_REQ_PTR:  mux = req_ptr;
      SEL_FLAGS:    mux = flags;
      SEL_RPLY_PTR: mux = rply_ptr;
      default:      mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (acc.rd)  rdata <= mux;
    else              rdata <= '0;
  end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       WIN_BYTES = 1024,
  parameter int unsigned       NUM_ALIAS = 24,
  parameter logic [DATA_W-1:0] REQ_OWN   = 32'h0000_0003,
  parameter logic [DATA_W-1:0] RSP_OWN   = 32'h0000_001C,
  parameter logic [DATA_W-1:0] RSP_IRQM  = 32'h0000_0001,
  parameter logic [DATA_W-1:0] REQ_IRQM  = 32'h0000_0014
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_rdata,
  input  logic              rsp_wr,
  input  logic              rsp_rd,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [DATA_W-1:0] rsp_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              req_irq,
  output logic              rsp_irq
);
  localparam int unsigned NSIDE = 2;

  logic [ADDR_W-1:0] addr_s  [NSIDE];
  logic              wr_s    [NSIDE];
  logic              rd_s    [NSIDE];
  logic [DATA_W-1:0] wdata_s [NSIDE];
  logic [DATA_W-1:0] rdata_s [NSIDE];
  mbox_acc_t         acc_s   [NSIDE];

  logic [DATA_W-1:0] req_ptr_q, rply_ptr_q, flags_q;

  assign addr_s[SIDE_REQ]  = req_addr;
  assign addr_s[SIDE_RSP]  = rsp_addr;
  assign wr_s[SIDE_REQ]    = req_wr;
  assign wr_s[SIDE_RSP]    = rsp_wr;
  assign rd_s[SIDE_REQ]    = req_rd;
  assign rd_s[SIDE_RSP]    = rsp_rd;
  assign wdata_s[SIDE_REQ] = req_wdata;
  assign wdata_s[SIDE_RSP] = rsp_wdata;
  assign req_rdata         = rdata_s[SIDE_REQ];
  assign rsp_rdata         = rdata_s[SIDE_RSP];

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    mbox_decode #(
      .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .NUM_ALIAS(NUM_ALIAS)
    ) u_dec (
      .addr(addr_s[s]), .wr(wr_s[s]), .rd(rd_s[s]), .acc(acc_s[s])
    );

    mbox_rdport #(.DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst(rst), .acc(acc_s[s]),
      .req_ptr(req_ptr_q), .flags(flags_q), .rply_ptr(rply_ptr_q),
      .rdata(rdata_s[s])
    );
  end

  // Each pointer is owned by one side; the other side's writes are dropped.
  mbox_ptr #(.DATA_W(DATA_W)) u_req_ptr (
    .clk(clk), .rst(rst),
    .we(acc_s[SIDE_REQ].wr && acc_s[SIDE_REQ].sel == SEL_REQ_PTR),
    .wdata(req_wdata), .q(req_ptr_q)
  );

  mbox_ptr #(.DATA_W(DATA_W)) u_rply_ptr (
    .clk(clk), .rst(rst),
    .we(acc_s[SIDE_RSP].wr && acc_s[SIDE_RSP].sel == SEL_RPLY_PTR),
    .wdata(rsp_wdata), .q(rply_ptr_q)
  );

  mbox_flags #(
    .DATA_W(DATA_W), .REQ_OWN(REQ_OWN), .RSP_OWN(RSP_OWN),
    .RSP_IRQM(RSP_IRQM), .REQ_IRQM(REQ_IRQM)
  ) u_flags (
    .clk(clk), .rst(rst),
    .req_we(acc_s[SIDE_REQ].wr && acc_s[SIDE_REQ].sel == SEL_FLAGS),
    .req_wdata(req_wdata),
    .rsp_we(acc_s[SIDE_RSP].wr && acc_s[SIDE_RSP].sel == SEL_FLAGS),
    .rsp_wdata(rsp_wdata),
    .flags_q(flags_q), .req_irq(req_irq), .rsp_irq(rsp_irq)
  );

endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_wr,
  input logic              req_rd,
  input logic              rsp_wr,
  input logic              rsp_rd,
  input logic [DATA_W-1:0] req_rdata,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              req_irq,
  input logic              rsp_irq
);
  // R4: only a requester write can raise the responder interrupt
  a_r4_rsp_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_irq) |-> $past(req_wr));

  // R5: only a responder write can raise the requester interrupt
  a_r5_req_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(req_irq) |-> $past(rsp_wr));

  // R4, R5: interrupts are levels that hold while no side writes
  a_r4_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (!req_wr && !rsp_wr) |=> ($stable(req_irq) && $stable(rsp_irq)));

  // R9: read data is zero after a cycle with no read
  a_r9_req_idle: assert property (@(posedge clk) disable iff (rst)
    !req_rd |=> (req_rdata == '0));
  a_r9_rsp_idle: assert property (@(posedge clk) disable iff (rst)
    !rsp_rd |=> (rsp_rdata == '0));

  // R10: reset clears every output
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!req_irq && !rsp_irq && req_rdata == '0 && rsp_rdata == '0));
endmodule

bind mbox_regs mbox_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd),
  .rsp_wr(rsp_wr), .rsp_rd(rsp_rd), .req_rdata(req_rdata),
  .rsp_rdata(rsp_rdata), .req_irq(req_irq), .rsp_irq(rsp_irq)
);

// File: tb/mbox_regs_tb.sv
module mbox_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_wr = 0, req_rd = 0, rsp_wr = 0, rsp_rd = 0;
  logic [15:0] req_addr = 0, rsp_addr = 0;
  logic [31:0] req_wdata = 0, rsp_wdata = 0;
  logic [31:0] req_rdata, rsp_rdata;
  logic        req_irq, rsp_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    bit          side;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  mbox_regs u_dut (
    .clk(clk), .rst(rst),
    .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_rdata(req_rdata),
    .rsp_wr(rsp_wr), .rsp_rd(rsp_rd), .rsp_addr(rsp_addr),
    .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata),
    .req_irq(req_irq), .rsp_irq(rsp_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issue one write, return on the next falling edge.
  task automatic wr(bit side, logic [15:0] a, logic [31:0] d);
    if (side) begin rsp_wr = 1; rsp_addr = a; rsp_wdata = d; end
    else      begin req_wr = 1; req_addr = a; req_wdata = d; end
    @(negedge clk);
    req_wr = 0; rsp_wr = 0;
  endtask

  task automatic wr2(logic [15:0] qa, logic [31:0] qd,
                     logic [15:0] pa, logic [31:0] pd);
    req_wr = 1; req_addr = qa; req_wdata = qd;
    rsp_wr = 1; rsp_addr = pa; rsp_wdata = pd;
    @(negedge clk);
    req_wr = 0; rsp_wr = 0;
  endtask

  // Driver: issue one read and push the expected value to the scoreboard.
  task automatic rd(bit side, logic [15:0] a, logic [31:0] exp, string tag);
    item_t it;
    it.side = side; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    if (side) begin rsp_rd = 1; rsp_addr = a; end
    else      begin req_rd = 1; req_addr = a; end
    @(negedge clk);
    req_rd = 0; rsp_rd = 0;
  endtask

  // Monitor: reads sampled at a rising edge are compared at the next falling edge.
  always begin
    bit l_req, l_rsp;
    @(posedge clk);
    l_req = req_rd && !rst;
    l_rsp = rsp_rd && !rst;
    @(negedge clk);
    if (l_req || l_rsp) begin
      if (sb.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R9 unexpected read result actual=%h expected=none", req_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(it.tag, it.side ? rsp_rdata : req_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10 req_irq after reset", {31'b0, req_irq}, 0);
    chk("R10 rsp_irq after reset", {31'b0, rsp_irq}, 0);
    rd(0, 16'h0000, 32'h0, "R10 request ptr after reset");
    rd(1, 16'h0004, 32'h0, "R10 flags after reset");

    // R1 request pointer
    wr(0, 16'h0000, 32'h1000_0040);
    rd(0, 16'h0000, 32'h1000_0040, "R1 requester reads ptr");
    rd(1, 16'h0000, 32'h1000_0040, "R1 responder reads ptr");
    wr(1, 16'h0000, 32'hDEAD_BEEF);
    rd(0, 16'h0000, 32'h1000_0040, "R1 responder write ignored");

    // R4 doorbell to responder
    wr(0, 16'h0004, 32'h1);
    chk("R4 rsp_irq raised", {31'b0, rsp_irq}, 1);
    chk("R5 req_irq stays low", {31'b0, req_irq}, 0);
    rd(1, 16'h0004, 32'h1, "R3 flags after doorbell");

    // R2 reply pointer
    wr(1, 16'h0008, 32'h1000_0040);
    wr(0, 16'h0008, 32'h5555_5555);
    rd(0, 16'h0008, 32'h1000_0040, "R2 reply ptr, requester write ignored");

    // R5 reply flags 0x14
    wr(1, 16'h0004, 32'h14);
    chk("R5 req_irq raised", {31'b0, req_irq}, 1);
    chk("R4 rsp_irq held", {31'b0, rsp_irq}, 1);
    rd(0, 16'h0004, 32'h15, "R5 flags after reply");

    // R3 ownership rules
    wr(1, 16'h0004, 32'h1);
    chk("R4 rsp_irq cleared by responder", {31'b0, rsp_irq}, 0);
    rd(1, 16'h0004, 32'h14, "R3 responder clears bit0");
    wr(0, 16'h0004, 32'h0);
    rd(0, 16'h0004, 32'h14, "R3 zero write no change");
    wr(0, 16'h0004, 32'h4);
    chk("R5 req_irq held by bit4", {31'b0, req_irq}, 1);
    wr(0, 16'h0004, 32'h10);
    chk("R5 req_irq cleared", {31'b0, req_irq}, 0);
    rd(0, 16'h0004, 32'h0, "R3 requester clears bits 2,4");
    wr(0, 16'h0004, 32'hFFFF_FFE2);
    rd(1, 16'h0004, 32'h2, "R3 high bits read zero");
    wr(1, 16'h0004, 32'h8);
    rd(1, 16'h0004, 32'hA, "R3 responder sets bit3");

    // R6 simultaneous writes
    wr2(16'h0004, 32'h1, 16'h0004, 32'h1);
    rd(0, 16'h0004, 32'hB, "R6 set wins over clear");
    chk("R6 rsp_irq after merge", {31'b0, rsp_irq}, 1);
    wr2(16'h0004, 32'h8, 16'h0004, 32'h10);
    rd(1, 16'h0004, 32'h13, "R6 set and clear merged");
    chk("R6 req_irq after merge", {31'b0, req_irq}, 1);

    // R7 aliasing
    rd(1, 16'h5C08, 32'h1000_0040, "R7 alias of reply ptr at top window");
    wr(1, 16'h2404, 32'h3);
    chk("R7 alias write clears rsp_irq", {31'b0, rsp_irq}, 0);
    rd(0, 16'h0004, 32'h10, "R7 flags after alias write");
    rd(0, 16'h6000, 32'h0, "R7 beyond region reads zero");
    wr(0, 16'h6004, 32'h1);
    chk("R7 beyond region write ignored", {31'b0, rsp_irq}, 0);
    rd(0, 16'h0004, 32'h10, "R7 flags unchanged");

    // R8 unmapped offsets
    rd(0, 16'h000C, 32'h0, "R8 offset 0xC reads zero");
    rd(1, 16'h0002, 32'h0, "R8 misaligned reads zero");
    wr(0, 16'h0010, 32'h1);
    wr(0, 16'h0006, 32'h1);
    chk("R8 unmapped write ignored", {31'b0, rsp_irq}, 0);
    rd(1, 16'h0004, 32'h10, "R8 flags unchanged");

    // R9 read shows pre-write value
    begin
      item_t it;
      it.side = 0; it.exp = 32'h10; it.tag = "R9 read during write sees old";
      sb.push_back(it);
      req_rd = 1; req_addr = 16'h0004;
      rsp_wr = 1; rsp_addr = 16'h0004; rsp_wdata = 32'h4;
      @(negedge clk);
      req_rd = 0; rsp_wr = 0;
    end
    rd(0, 16'h0004, 32'h14, "R9 next read sees new");

    // R10 reset mid-run
    wr(0, 16'h0004, 32'h1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R10 req_irq cleared", {31'b0, req_irq}, 0);
    chk("R10 rsp_irq cleared", {31'b0, rsp_irq}, 0);
    rd(0, 16'h0000, 32'h0, "R10 request ptr cleared");
    rd(0, 16'h0004, 32'h0, "R10 flags cleared");
    rd(1, 16'h0008, 32'h0, "R10 reply ptr cleared");

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R9 missing read results actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule